// File: doc/BRIEF.md
# Shift-Based LMS Coefficient Update Unit

This block updates the four coefficients of an adaptive LMS filter without a single multiplier. The step size is a fixed power of two, so the error that arrives here is already scaled. The block splits that error into a sign and a magnitude. Only the leading one of the magnitude is kept, and its bit position becomes a right-shift amount. Each tap sample is shifted arithmetically by that amount, and the result is the tap's coefficient increment.

Each increment is then serialized, least significant bit first. A one-bit serial adder with a carry flop folds it into the tap's coefficient, and the error sign decides whether it adds or subtracts. A pulse on `start` launches an update. The update takes W clock cycles, during which the block reports `busy` and shows the current increment bit of every tap on `slice_out`. A one-cycle `done` then marks the moment when `coef_out` holds the new coefficients.

Top module: `lmsu_update`

## Requirements
- R1: After reset every coefficient on `coef_out` is zero, and `busy`, `done` and `slice_out` are low.
- R2: `err_in` is W-bit two's complement. Its MSB is the sign and its absolute value is the magnitude, so -2^(W-1) has magnitude 2^(W-1). A negative error subtracts the increment from each coefficient, and a non-negative error adds it.
- R3: If the magnitude's highest set bit is at position p, with 1 <= p <= W-1, the shift amount is W-1-p. For W=8, the values 128, 64, 32, 16, 8, 4 and 2 give shifts 0 through 6.
- R4: A magnitude of 0 or 1 gives a zero increment for every tap. The slices stay low and the coefficients come out unchanged.
- R5: The increment of tap i is `samp_in[i*W +: W]`, read as signed, shifted right arithmetically by the shift amount, with sign extension.
- R6: During the W busy cycles that follow a `start`, `slice_out[i]` shows bit k of tap i's increment in busy cycle k, with k counted from 0 and LSB first.
- R7: A `start` seen while idle raises `busy` at the next edge. `busy` stays high for exactly W cycles. `done` is high for the single cycle after `busy` falls.
- R8: Coefficient arithmetic wraps modulo 2^W.
- R9: A `start` asserted while `busy` is high is ignored. Neither the update in flight nor its result changes.
- R10: While `busy` is low, `coef_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an update using `err_in` and `samp_in` |
| err_in | input | W | Scaled error, two's complement |
| samp_in | input | TAPS*W | Tap samples, tap i at bits [i*W +: W] |
| busy | output | 1 | Serial update in progress |
| done | output | 1 | One-cycle pulse when the coefficients are final |
| coef_out | output | TAPS*W | Coefficients, tap i at bits [i*W +: W], valid while `busy` is low |
| slice_out | output | TAPS | Current increment bit-slice of each tap |

## Verification
The hardest situations to reach from the ports are an overflow of a coefficient and a second `start` that lands in the middle of a serial pass. Both are mixed up with the internal carry and the rotating coefficient register.

The stimulus first builds a known coefficient value through a chain of updates. It then drives the most negative error against the most negative sample, which forces a carry out of the top bit. In a separate pass it raises `start` again halfway through the update, with a different error, and checks that both the reassembled slices and the final coefficients still match the first command.

The bench also walks the leading one through every position, including the error values 0 and 1.

// File: rtl/lmsu_pkg.sv
package lmsu_pkg;

  // Index of the highest set bit, or -1 when the vector is all zeros.
  function automatic int lead_one_index(input logic [63:0] v);
    int idx;
    idx = -1;
    for (int b = 0; b < 64; b++) begin
      if (v[b]) idx = b;
    end
    return idx;
  endfunction

endpackage

// File: rtl/lmsu_shift_ctl.sv
module lmsu_shift_ctl #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  err,
  output logic          neg,
  output logic          zero_inc,
  output logic [SW-1:0] shamt
);
  logic [W-1:0] mag;
  int           pos;

  function automatic logic [W-1:0] abs_of(input logic [W-1:0] e);
    return e[W-1] ? (~e + 1'b1) : e;
  endfunction

  always_comb begin
    neg      = err[W-1];
    mag      = abs_of(err);
    pos      = lmsu_pkg::lead_one_index({{(64-W){1'b0}}, mag});
    zero_inc = (pos < 1);
    shamt    = zero_inc ? '0 : SW'(W - 1 - pos);
  end
endmodule

// File: rtl/lmsu_seq.sv
module lmsu_seq #(
  parameter int W  = 8,
  parameter int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  assign load = start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lmsu_tap.sv
module lmsu_tap #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          sub,
  input  logic          zero_inc,
  input  logic [SW-1:0] shamt,
  input  logic [W-1:0]  sample,
  output logic [W-1:0]  coef,
  output logic          slice
);
  logic [W-1:0] piso;
  logic [W-1:0] acc;
  logic         carry;
  logic [W-1:0] inc;
  logic         bit_in;
  logic         sum_bit;
  logic         carry_nx;

  function automatic logic [W-1:0] ashr(input logic [W-1:0] x, input logic [SW-1:0] sh);
    logic signed [W-1:0] xs;
    xs = x;
    return xs >>> sh;
  endfunction

  always_comb begin
    inc      = zero_inc ? '0 : ashr(sample, shamt);
    bit_in   = piso[0] ^ sub;
    sum_bit  = acc[0] ^ bit_in ^ carry;
    carry_nx = (acc[0] & bit_in) | (acc[0] & carry) | (bit_in & carry);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      piso  <= '0;
      acc   <= '0;
      carry <= 1'b0;
    end else if (load) begin
      piso  <= inc;
      carry <= sub;
    end else if (step) begin
      piso  <= {1'b0, piso[W-1:1]};
      acc   <= {sum_bit, acc[W-1:1]};
      carry <= carry_nx;
    end
  end

  assign coef  = acc;
  assign slice = piso[0];
endmodule

// File: rtl/lmsu_update.sv
module lmsu_update #(
  parameter int W    = 8,
  parameter int TAPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      err_in,
  input  logic [TAPS*W-1:0] samp_in,
  output logic              busy,
  output logic              done,
  output logic [TAPS*W-1:0] coef_out,
  output logic [TAPS-1:0]   slice_out
);
  localparam int SW = $clog2(W);

  logic          load;
  logic          neg;
  logic          zero_inc;
  logic [SW-1:0] shamt;
  logic          sub_q;

  lmsu_shift_ctl #(.W(W), .SW(SW)) u_ctl (
    .err(err_in), .neg(neg), .zero_inc(zero_inc), .shamt(shamt)
  );

  lmsu_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sub_q <= 1'b0;
    else if (load) sub_q <= neg;
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    lmsu_tap #(.W(W), .SW(SW)) u_tap (
      .clk(clk), .rst_n(rst_n), .load(load), .step(busy),
      .sub(load ? neg : sub_q), .zero_inc(zero_inc), .shamt(shamt),
      .sample(samp_in[i*W +: W]), .coef(coef_out[i*W +: W]),
      .slice(slice_out[i])
    );
  end
endmodule

// File: rtl/lmsu_update_chk.sv
module lmsu_update_chk #(
  parameter int W    = 8,
  parameter int TAPS = 4,
  parameter int SW   = $clog2(W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              zero_inc,
  input logic [SW-1:0]     shamt,
  input logic [TAPS*W-1:0] coef_out,
  input logic [TAPS-1:0]   slice_out
);
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R7
  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(coef_out)); // R10
  AST_IDLE_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (slice_out == '0)); // R6
  AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_inc |-> (shamt <= SW'(W - 2))); // R3
endmodule

bind lmsu_update lmsu_update_chk #(.W(W), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .zero_inc(zero_inc), .shamt(shamt), .coef_out(coef_out),
  .slice_out(slice_out)
);

// File: tb/lmsu_update_test.sv
module lmsu_update_test;
  localparam int W    = 8;
  localparam int TAPS = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [W-1:0]      err_in = '0;
  logic [TAPS*W-1:0] samp_in = '0;
  logic              busy, done;
  logic [TAPS*W-1:0] coef_out;
  logic [TAPS-1:0]   slice_out;

  int vectors = 0;
  int miscompares = 0;
  logic [W-1:0] model [TAPS];

  always #2 clk = ~clk;

  lmsu_update #(.W(W), .TAPS(TAPS)) uut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Expected increment, derived by threshold comparison rather than priority search.
  function automatic logic [W-1:0] exp_inc(input logic [W-1:0] e, input logic [W-1:0] x);
    int m, sh;
    logic signed [W-1:0] xs;
    m  = e[W-1] ? (1 << W) - int'(e) : int'(e);
    sh = -1;
    for (int p = 1; p < W; p++) if (m >= (1 << p)) sh = W - 1 - p;
    if (sh < 0) return '0;
    xs = x;
    return W'(xs >>> sh);
  endfunction

  task automatic run_update(input string tag, input logic [W-1:0] e,
                            input logic [TAPS*W-1:0] s, input bit poke);
    logic [W-1:0] got_inc [TAPS];
    logic [W-1:0] inc;
    @(negedge clk);
    err_in = e; samp_in = s; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (k > 0) @(negedge clk);
      if (busy !== 1'b1) check({tag, " R7 busy"}, 32'(busy), 32'd1);
      for (int i = 0; i < TAPS; i++) got_inc[i][k] = slice_out[i];
      if (poke && k == 3) begin
        start = 1'b1; err_in = ~e; samp_in = ~s;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    check({tag, " R7 done"}, 32'(done), 32'd1);
    check({tag, " R7 busy low"}, 32'(busy), 32'd0);
    for (int i = 0; i < TAPS; i++) begin
      inc = exp_inc(e, s[i*W +: W]);
      check({tag, " R6 R5 R3 slices"}, 32'(got_inc[i]), 32'(inc));
      model[i] = e[W-1] ? model[i] - inc : model[i] + inc;
      check({tag, " R2 R8 coef"}, 32'(coef_out[i*W +: W]), 32'(model[i]));
    end
    @(negedge clk);
    check({tag, " R7 done pulse"}, 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < TAPS; i++)
      check({tag, " R10 hold"}, 32'(coef_out[i*W +: W]), 32'(model[i]));
  endtask

  task automatic t_reset;
    check("R1 coef", coef_out, '0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 slice", 32'(slice_out), 32'd0);
  endtask

  task automatic t_basic;
    run_update("R2 pos", 8'd64, {8'd100, 8'd37, 8'hC8, 8'h7F}, 1'b0);
    run_update("R2 neg", 8'hE0, {8'd12, 8'h81, 8'd55, 8'hF3}, 1'b0);
  endtask

  task automatic t_all_shifts;
    for (int p = 1; p < W; p++)
      run_update("R3 walk", W'(1 << p) | W'((1 << p) - 1 >> 1), {8'h96, 8'd77, 8'hFF, 8'd1}, 1'b0);
  endtask

  task automatic t_zero;
    run_update("R4 zero", 8'd0, {8'h7F, 8'h80, 8'd9, 8'hAA}, 1'b0);
    run_update("R4 one", 8'd1, {8'h7F, 8'h80, 8'd9, 8'hAA}, 1'b0);
    run_update("R4 minus one", 8'hFF, {8'h7F, 8'h80, 8'd9, 8'hAA}, 1'b0);
  endtask

  task automatic t_wrap;
    run_update("R8 wrap a", 8'h80, {4{8'h80}}, 1'b0);
    run_update("R8 wrap b", 8'h80, {8'h01, 8'h7F, 8'h80, 8'hFF}, 1'b0);
    run_update("R8 wrap c", 8'd127, {4{8'h7F}}, 1'b0);
  endtask

  task automatic t_ignore;
    run_update("R9 ignore", 8'd20, {8'd90, 8'hB0, 8'd3, 8'h44}, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < TAPS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_all_shifts;
    t_zero;
    t_wrap;
    t_ignore;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    miscompares++;
    vectors++;
    $display("FAIL watchdog got=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule